// File: doc/BRIEF.md
# Cascadable Latched Magnitude Comparator

This block compares two words, P and Q, built from a parameter number of 8-bit slices, and reports the result on two registered decision flags: one for P above Q and one for P below Q. A mode input chooses plain unsigned ordering or two's-complement signed ordering of the full word. The P operand goes through a holding register with its own load enable. One operand can therefore be kept fixed while a stream of Q values is compared against it.

Two carry-in decision inputs enter the least significant slice. A slice only uses them when its bytes are equal. A slice passes its own decision to the next more significant slice, with no gating in between. Only the top slice honours signed mode, and every lower slice orders its byte as unsigned. Tie both carry-in inputs to 0 to get plain comparison. Equal words then show as both flags low.

Top module: `cmp_chain`

## Requirements
- R1: While `p_en_i` is 1 at a rising edge, the held P word loads `p_i`. While it is 0, the held P word keeps its value and changes on `p_i` are ignored.
- R2: While `rst_n` is 0, the held P word, the sampled Q word, the sampled carry-in pair and both outputs are 0. With no load after reset, P compares as zero.
- R3: With `mode_unsigned_i` = 1, the words are ordered as unsigned binary numbers.
- R4: With `mode_unsigned_i` = 0, the words are ordered as two's-complement signed numbers. Bit W-1 is the sign bit.
- R5: When P is above Q, `gt_o`=1 and `lt_o`=0. When P is below Q, `gt_o`=0 and `lt_o`=1. Both hold whatever the carry-in inputs are.
- R6: When P equals Q, `gt_o` equals the sampled `cin_gt_i` and `lt_o` equals the sampled `cin_lt_i`. With both carry-ins at 0, equal words give both outputs 0.
- R7: In a multi-slice word, the most significant differing byte decides the result. Bytes below the top slice are ordered as unsigned, even in signed mode.
- R8: If the words are equal and both carry-in inputs are 1, both outputs are 1. No correction is applied.
- R9: Inputs sampled at rising edge k appear on the outputs after rising edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| p_en_i | input | 1 | Load enable for the held P word |
| mode_unsigned_i | input | 1 | 1 selects unsigned ordering, 0 selects signed ordering |
| p_i | input | 8*STAGES | P operand |
| q_i | input | 8*STAGES | Q operand |
| cin_gt_i | input | 1 | Carry-in "above" decision from a lower chain |
| cin_lt_i | input | 1 | Carry-in "below" decision from a lower chain |
| gt_o | output | 1 | P above Q (registered) |
| lt_o | output | 1 | P below Q (registered) |

## Verification
The bench compares 0x7F00 against 0x8000 in both modes. A design that ignored the mode, or flipped the wrong bit, would give the same answer both times. It also compares 0x007F against 0x0080 in signed mode, which catches a design that applied signed ordering to the low slice. Equal words are tried with each carry-in pattern, including both high, which exposes a design that masks the carry-ins or gates them off on equality. P is loaded, and then `p_i` changes while the enable is low, so a register that kept following the input would flip the result. A check one edge early shows whether the design has too many or too few pipeline registers.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int SLICE_W = 8;

    typedef struct packed {
        logic gt;
        logic lt;
    } decision_t;
endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
    import cmp_pkg::*;
#(
    parameter int  W         = SLICE_W,
    parameter bit  TOP_SLICE = 1'b0
) (
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    input  logic         mode_unsigned,
    input  decision_t    cin,
    output decision_t    cout
);
    logic         flip_msb;
    logic [W-1:0] p_key;
    logic [W-1:0] q_key;
    logic         above;
    logic         below;

    generate
        if (TOP_SLICE) begin : g_signed_capable
            assign flip_msb = ~mode_unsigned;
        end else begin : g_unsigned_only
            assign flip_msb = 1'b0;
        end
    endgenerate

    // Signed order equals unsigned order once both sign bits are inverted
    always_comb begin
        p_key        = p;
        q_key        = q;
        p_key[W-1]   = p[W-1] ^ flip_msb;
        q_key[W-1]   = q[W-1] ^ flip_msb;
        above        = p_key > q_key;
        below        = p_key < q_key;
        cout.gt      = above | (~below & cin.gt);
        cout.lt      = below | (~above & cin.lt);
    end
endmodule

// File: rtl/cmp_operand_reg.sv
module cmp_operand_reg
    import cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         p_en,
    input  logic         mode_unsigned,
    input  logic [W-1:0] p_in,
    input  logic [W-1:0] q_in,
    input  decision_t    cin_in,
    output logic [W-1:0] p_held,
    output logic [W-1:0] q_smp,
    output logic         mode_smp,
    output decision_t    cin_smp
);
    typedef struct packed {
        logic [W-1:0] p;
        logic [W-1:0] q;
        logic         mode;
        decision_t    cin;
    } opnd_t;

    opnd_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        if (p_en) begin
            st_d.p = p_in;
        end
        st_d.q    = q_in;
        st_d.mode = mode_unsigned;
        st_d.cin  = cin_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign p_held   = st_q.p;
    assign q_smp    = st_q.q;
    assign mode_smp = st_q.mode;
    assign cin_smp  = st_q.cin;

    // R1: with the enable low the held word does not move
    assert_p_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !p_en |=> $stable(st_q.p));

    // R1: with the enable high the held word takes the input
    assert_p_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        p_en |=> (st_q.p == $past(p_in)));
endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
    import cmp_pkg::*;
#(
    parameter  int STAGES = 2,
    localparam int W      = SLICE_W * STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         p_en_i,
    input  logic         mode_unsigned_i,
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] q_i,
    input  logic         cin_gt_i,
    input  logic         cin_lt_i,
    output logic         gt_o,
    output logic         lt_o
);
    logic [W-1:0] p_q;
    logic [W-1:0] q_q;
    logic         mode_q;
    decision_t    cin_q;
    decision_t    cin_d;
    decision_t    link [STAGES+1];
    decision_t    res_d, res_q;

    assign cin_d.gt = cin_gt_i;
    assign cin_d.lt = cin_lt_i;

    cmp_operand_reg #(.W(W)) u_opnd (
        .clk           (clk),
        .rst_n         (rst_n),
        .p_en          (p_en_i),
        .mode_unsigned (mode_unsigned_i),
        .p_in          (p_i),
        .q_in          (q_i),
        .cin_in        (cin_d),
        .p_held        (p_q),
        .q_smp         (q_q),
        .mode_smp      (mode_q),
        .cin_smp       (cin_q)
    );

    assign link[0] = cin_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_slice
            cmp_slice #(
                .W         (SLICE_W),
                .TOP_SLICE (s == STAGES - 1)
            ) u_slice (
                .p             (p_q[s*SLICE_W +: SLICE_W]),
                .q             (q_q[s*SLICE_W +: SLICE_W]),
                .mode_unsigned (mode_q),
                .cin           (link[s]),
                .cout          (link[s+1])
            );
        end
    endgenerate

    always_comb begin
        res_d = link[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign gt_o = res_q.gt;
    assign lt_o = res_q.lt;

    // R3: unsigned mode, P above Q in the sampled words
    assert_unsigned_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_q && (p_q > q_q)) |-> (gt_o && !lt_o));

    // R4: signed mode, P below Q in the sampled words
    assert_signed_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mode_q && ($signed(p_q) < $signed(q_q))) |-> (lt_o && !gt_o));

    // R6: equal words pass the sampled carry-in pair through
    assert_equal_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(p_q == q_q) |-> ((gt_o == $past(cin_q.gt)) && (lt_o == $past(cin_q.lt))));

    // R8: both flags high only when both carry-ins were high
    assert_both_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gt_o && lt_o) |-> $past(cin_q.gt && cin_q.lt));
endmodule

// File: tb/cmp_chain_tb.sv
module cmp_chain_tb;
    localparam int STAGES = 2;
    localparam int W      = 8 * STAGES;
    localparam int NV     = 13;

    // {mode_unsigned, cin_gt, cin_lt, p, q, exp_gt, exp_lt}
    localparam logic [36:0] VECS [NV] = '{
        {1'b1, 1'b0, 1'b0, 16'h7F00, 16'h8000, 1'b0, 1'b1}, // R3
        {1'b0, 1'b0, 1'b0, 16'h7F00, 16'h8000, 1'b1, 1'b0}, // R4
        {1'b1, 1'b0, 1'b0, 16'h007F, 16'h0080, 1'b0, 1'b1}, // R7
        {1'b0, 1'b0, 1'b0, 16'h007F, 16'h0080, 1'b0, 1'b1}, // R7
        {1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 1'b0, 1'b1}, // R4
        {1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 1'b1, 1'b0}, // R3
        {1'b1, 1'b1, 1'b0, 16'h1234, 16'h1234, 1'b1, 1'b0}, // R6
        {1'b0, 1'b0, 1'b1, 16'hABCD, 16'hABCD, 1'b0, 1'b1}, // R6
        {1'b1, 1'b0, 1'b0, 16'h5555, 16'h5555, 1'b0, 1'b0}, // R6
        {1'b1, 1'b1, 1'b1, 16'h0101, 16'h0101, 1'b1, 1'b1}, // R8
        {1'b1, 1'b0, 1'b1, 16'h0200, 16'h01FF, 1'b1, 1'b0}, // R5
        {1'b0, 1'b1, 1'b0, 16'h8000, 16'h8001, 1'b0, 1'b1}, // R5
        {1'b0, 1'b0, 1'b0, 16'h0180, 16'h017F, 1'b1, 1'b0}  // R7
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         p_en_i = 1'b0;
    logic         mode_unsigned_i = 1'b1;
    logic [W-1:0] p_i = '0;
    logic [W-1:0] q_i = '0;
    logic         cin_gt_i = 1'b0;
    logic         cin_lt_i = 1'b0;
    logic         gt_o;
    logic         lt_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cmp_chain #(.STAGES(STAGES)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .p_en_i          (p_en_i),
        .mode_unsigned_i (mode_unsigned_i),
        .p_i             (p_i),
        .q_i             (q_i),
        .cin_gt_i        (cin_gt_i),
        .cin_lt_i        (cin_lt_i),
        .gt_o            (gt_o),
        .lt_o            (lt_o)
    );

    task automatic check(input string req, input logic eg, input logic el);
        checks++;
        if (gt_o !== eg || lt_o !== el) begin
            errors++;
            $display("FAIL %s: gt/lt actual %b%b expected %b%b", req, gt_o, lt_o, eg, el);
        end
    endtask

    task automatic apply(input logic en, input logic m, input logic cg, input logic cl,
                         input logic [W-1:0] p, input logic [W-1:0] q);
        @(negedge clk);
        p_en_i = en; mode_unsigned_i = m; cin_gt_i = cg; cin_lt_i = cl;
        p_i = p; q_i = q;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        p_i = '1; q_i = 16'h0001; cin_gt_i = 1'b1; cin_lt_i = 1'b1; p_en_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 reset outputs", 1'b0, 1'b0);
        p_en_i = 1'b0; q_i = '0; cin_gt_i = 1'b0; cin_lt_i = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R2 held P cleared equals zero Q", 1'b0, 1'b0);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0001);
        check("R2 held P cleared below one", 1'b0, 1'b1);

        // table walk, P loaded every vector
        for (int i = 0; i < NV; i++) begin
            apply(1'b1, VECS[i][36], VECS[i][35], VECS[i][34],
                  VECS[i][33:18], VECS[i][17:2]);
            check($sformatf("R3-vector %0d (R5/R6/R7/R8 class)", i), VECS[i][1], VECS[i][0]);
        end

        // R1: load 0x0050, then drop enable and change P
        apply(1'b1, 1'b1, 1'b0, 1'b0, 16'h0050, 16'h0050);
        check("R1 loaded equal", 1'b0, 1'b0);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0040);
        check("R1 held P above Q", 1'b1, 1'b0);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0050);
        check("R1 held P equal Q", 1'b0, 1'b0);

        // R9: latency of two edges
        @(negedge clk);
        q_i = 16'h0060;
        @(posedge clk); @(negedge clk);
        check("R9 unchanged after one edge", 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R9 updated after two edges", 1'b0, 1'b1);

        // R5: carry-ins ignored when words differ
        apply(1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h0060);
        check("R5 carry-ins ignored", 1'b0, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule